// File: doc/BRIEF.md
# Locked Bus Cycle and Hold Arbiter

This block sits between a processor's bus unit and the external bus. It starts each bus cycle on an address strobe and tracks the cycle until its final ready. It drives a lock output across a run of cycles that the bus unit flags as locked. It also decides when an external bus hold request may be acknowledged. The lock output rises in the same clock as the strobe of the first locked cycle. It stays up through every cycle of the run, and through the idle clocks between them. It falls only in the clock after the final ready of the cycle marked as the last of the run. After it falls, a configurable number of clocks must pass before another locked cycle may start. This gives back-to-back runs a lock-free gap.

Cycle requests arrive on a valid/ready handshake. The request carries three attribute bits: locked, last of run, and memory/IO. A request is taken on a clock edge where `cyc_valid` and `cyc_ready` are both high. While `cyc_valid` is high the attributes must stay stable, and the requester must not drop `cyc_valid` until the request is taken. `cyc_ready` may depend on `cyc_lock`. This is how a locked request is held back during the gap while an unlocked one is not. The strobe and the memory/IO output appear together in the clock after the handshake.

A bus hold request is never acknowledged while lock is up. Address-hold and back-off work regardless of lock. Address-hold stops new cycles from starting. Back-off aborts the cycle in flight and keeps lock up. When back-off is removed, the block reissues the strobe for the same cycle.

Top module: `buslock_arb`

## Requirements
- R1: While reset is low, and in the first clock after it is released, `lock`, `hlda` and `ads` are 0. When idle with no hold, address-hold or back-off request, `cyc_ready` is 1.
- R2: A handshake makes `ads` high for exactly the next clock, with `mio` equal to the request's memory/IO bit in that clock. `cyc_ready` is 0 from then until the cycle's final ready.
- R3: When the first locked request of a run is taken, `lock` rises in the same clock that `ads` is high.
- R4: `lock` stays 1 across the cycles of a run and the idle clocks between them. It falls in the clock after `brdy` ends the cycle whose last-of-run bit is 1.
- R5: For GAP_CLKS clocks (default 1) after `lock` falls, `cyc_ready` is 0 for a request with `cyc_lock`=1. `lock` is therefore low for at least GAP_CLKS+1 clocks between runs.
- R6: `hlda` is never 1 while `lock` is 1. A `hold_req` is acknowledged in the clock after it is seen with no cycle in flight and `lock` low. `cyc_ready` is 0 while `hlda` is 1, or while `hold_req` is pending with `lock` low.
- R7: A `hold_req` pending when a run ends is acknowledged in the clock after `lock` falls. It takes precedence over a waiting locked request.
- R8: `ahold_req` makes `stall` 1 and `cyc_ready` 0. It does not change `lock`, and a cycle already in flight still completes on `brdy`.
- R9: `boff_req` during a cycle makes `stall` 1, keeps `lock` unchanged and makes `brdy` have no effect. In the clock after `boff_req` is removed, `ads` is reissued for the same cycle, which then completes on a later `brdy`.
- R10: `hlda` falls in the clock after `hold_req` is removed.
- R11: `brdy` has no effect when no cycle is in flight or in the clock where `ads` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cyc_valid | input | 1 | Bus unit has a cycle request |
| cyc_lock | input | 1 | Request is part of a locked run |
| cyc_last | input | 1 | Request is the last cycle of its locked run |
| cyc_mio | input | 1 | Request attribute: 1 memory, 0 IO |
| cyc_ready | output | 1 | Request may be taken this clock |
| brdy | input | 1 | Final ready of the cycle in flight |
| hold_req | input | 1 | External bus hold request |
| ahold_req | input | 1 | Address-hold request |
| boff_req | input | 1 | Back-off request |
| ads | output | 1 | Address strobe, one clock per (re)started cycle |
| mio | output | 1 | Memory/IO definition, valid while `ads` is high |
| lock | output | 1 | Bus lock, active high |
| hlda | output | 1 | Hold acknowledge |
| stall | output | 1 | Bus unit must wait (address-hold or back-off in effect) |

## Verification
Some rules are checked on every cycle. Lock only rises together with a strobe. It only falls after an unblocked ready. It stays low in the clock after it falls. Hold acknowledge never overlaps lock and only rises after a lock-free clock. No strobe appears while hold is acknowledged. Back-off never drops lock. The bench's scenarios are needed for the rest. These cover the exact ordering of a hold pending at the end of a run against a waiting locked request, and the refusal of locked requests during the gap while the bus is otherwise free. They also cover the reissue of the strobe after back-off, and ready being ignored in the strobe clock.

// File: rtl/buslock_pkg.sv
package buslock_pkg;
  typedef struct packed {
    logic locked;
    logic last;
    logic mem;
  } cyc_attr_t;
endpackage

// File: rtl/buslock_cyc.sv
module buslock_cyc
  import buslock_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      take,
  input  cyc_attr_t take_attr,
  input  logic      brdy,
  input  logic      boff_req,
  output logic      busy,
  output logic      strobe,
  output logic      aborted,
  output logic      done,
  output cyc_attr_t cur_attr
);
  // ready is only meaningful once the strobe clock is over and no back-off is active
  assign done = busy && !strobe && !aborted && !boff_req && brdy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      strobe   <= 1'b0;
      aborted  <= 1'b0;
      cur_attr <= '0;
    end else begin
      strobe <= 1'b0;
      if (take) begin
        busy     <= 1'b1;
        strobe   <= 1'b1;
        cur_attr <= take_attr;
      end else if (busy) begin
        if (boff_req) begin
          aborted <= 1'b1;
        end else if (aborted) begin
          aborted <= 1'b0;
          strobe  <= 1'b1;       // restart the same cycle
        end else if (done) begin
          busy <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/buslock_lockctl.sv
module buslock_lockctl #(
  parameter int GAP_CLKS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic take_locked,
  input  logic done,
  input  logic cur_locked,
  input  logic cur_last,
  output logic lock_q,
  output logic gap_active
);
  localparam int GW = $clog2(GAP_CLKS + 1);
  localparam logic [GW-1:0] GAP_LOAD = GW'(GAP_CLKS);

  logic [GW-1:0] gap_cnt;

  assign gap_active = (gap_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q  <= 1'b0;
      gap_cnt <= '0;
    end else begin
      if (take && take_locked) begin
        lock_q <= 1'b1;
      end else if (done && cur_locked && cur_last) begin
        lock_q  <= 1'b0;
        gap_cnt <= GAP_LOAD;
      end else if (gap_active) begin
        gap_cnt <= gap_cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/buslock_holdctl.sv
module buslock_holdctl (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_req,
  input  logic busy,
  input  logic lock_q,
  output logic hlda_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hlda_q <= 1'b0;
    end else begin
      hlda_q <= hold_req && (hlda_q || (!busy && !lock_q));
    end
  end
endmodule

// File: rtl/buslock_arb.sv
module buslock_arb
  import buslock_pkg::*;
#(
  parameter int GAP_CLKS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_valid,
  input  logic cyc_lock,
  input  logic cyc_last,
  input  logic cyc_mio,
  output logic cyc_ready,
  input  logic brdy,
  input  logic hold_req,
  input  logic ahold_req,
  input  logic boff_req,
  output logic ads,
  output logic mio,
  output logic lock,
  output logic hlda,
  output logic stall
);
  cyc_attr_t req_attr, cur_attr;
  logic busy, strobe, aborted, done, take, lock_q, gap_active, hlda_q;

  assign req_attr = '{locked: cyc_lock, last: cyc_last, mem: cyc_mio};

  // hold wins over new cycles only once lock is down
  assign cyc_ready = !busy && !ahold_req && !boff_req && !hlda_q
                   && !(hold_req && !lock_q)
                   && !(cyc_lock && gap_active);
  assign take = cyc_valid && cyc_ready;

  buslock_cyc u_cyc (
    .clk(clk), .rst_n(rst_n), .take(take), .take_attr(req_attr),
    .brdy(brdy), .boff_req(boff_req), .busy(busy), .strobe(strobe),
    .aborted(aborted), .done(done), .cur_attr(cur_attr)
  );

  buslock_lockctl #(.GAP_CLKS(GAP_CLKS)) u_lock (
    .clk(clk), .rst_n(rst_n), .take(take), .take_locked(cyc_lock),
    .done(done), .cur_locked(cur_attr.locked), .cur_last(cur_attr.last),
    .lock_q(lock_q), .gap_active(gap_active)
  );

  buslock_holdctl u_hold (
    .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .busy(busy),
    .lock_q(lock_q), .hlda_q(hlda_q)
  );

  assign ads   = strobe;
  assign mio   = cur_attr.mem;
  assign lock  = lock_q;
  assign hlda  = hlda_q;
  assign stall = ahold_req || boff_req || aborted;
endmodule

// File: rtl/buslock_arb_chk.sv
module buslock_arb_chk (
  input logic clk,
  input logic rst_n,
  input logic cyc_valid,
  input logic cyc_lock,
  input logic cyc_last,
  input logic cyc_mio,
  input logic cyc_ready,
  input logic brdy,
  input logic hold_req,
  input logic ahold_req,
  input logic boff_req,
  input logic ads,
  input logic mio,
  input logic lock,
  input logic hlda,
  input logic stall
);
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (!lock && !hlda && !ads));

  a_r3_lock_rises_with_ads: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> ads);

  a_r4_lock_falls_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock) |-> ($past(brdy) && !$past(boff_req)));

  a_r5_gap_clock: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock) |=> !lock);

  a_r6_no_hlda_in_lock: assert property (@(posedge clk) disable iff (!rst_n)
    !(lock && hlda));

  a_r6_hlda_after_free: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hlda) |-> !$past(lock));

  a_r6_no_ads_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> !ads);

  a_r9_boff_keeps_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && boff_req) |=> lock);

  a_r8_ahold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    ahold_req |-> (stall && !cyc_ready));
endmodule

bind buslock_arb buslock_arb_chk u_chk (.*);

// File: tb/sim_buslock_arb.sv
module sim_buslock_arb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_valid = 1'b0, cyc_lock = 1'b0, cyc_last = 1'b0, cyc_mio = 1'b0;
  logic brdy = 1'b0, hold_req = 1'b0, ahold_req = 1'b0, boff_req = 1'b0;
  logic cyc_ready, ads, mio, lock, hlda, stall;
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  buslock_arb u0 (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_lock(cyc_lock),
    .cyc_last(cyc_last), .cyc_mio(cyc_mio), .cyc_ready(cyc_ready), .brdy(brdy),
    .hold_req(hold_req), .ahold_req(ahold_req), .boff_req(boff_req),
    .ads(ads), .mio(mio), .lock(lock), .hlda(hlda), .stall(stall)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic issue(input logic lk, input logic lst, input logic m);
    cyc_valid = 1'b1; cyc_lock = lk; cyc_last = lst; cyc_mio = m;
    #1;
    while (!cyc_ready) begin tick(); #1; end
    tick();
    cyc_valid = 1'b0;
  endtask

  task automatic complete();
    brdy = 1'b1;
    tick();          // strobe clock: ready ignored
    tick();
    brdy = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) tick();
    chk("R1 lock in reset", lock, 1'b0);
    chk("R1 hlda in reset", hlda, 1'b0);
    chk("R1 ads in reset", ads, 1'b0);
    rst_n = 1'b1;
    tick();
    chk("R1 lock after reset", lock, 1'b0);
    chk("R1 ads after reset", ads, 1'b0);
    #1 chk("R1 ready idle", cyc_ready, 1'b1);
  endtask

  task automatic t_plain();
    issue(1'b0, 1'b0, 1'b1);
    chk("R2 ads", ads, 1'b1);
    chk("R2 mio", mio, 1'b1);
    chk("R3 no lock plain", lock, 1'b0);
    chk("R2 ready busy", cyc_ready, 1'b0);
    brdy = 1'b1;
    tick();
    chk("R2 ads one clock", ads, 1'b0);
    #1 chk("R11 brdy in ads clock ignored", cyc_ready, 1'b0);
    tick();
    brdy = 1'b0;
    #1 chk("R2 ready after done", cyc_ready, 1'b1);
    brdy = 1'b1;
    tick();
    brdy = 1'b0;
    chk("R11 idle brdy no ads", ads, 1'b0);
    tick();
  endtask

  task automatic t_lockrun();
    issue(1'b1, 1'b0, 1'b1);
    chk("R3 ads first locked", ads, 1'b1);
    chk("R3 lock with ads", lock, 1'b1);
    complete();
    chk("R4 lock held mid run", lock, 1'b1);
    tick();
    chk("R4 lock held idle", lock, 1'b1);
    issue(1'b1, 1'b1, 1'b0);
    chk("R2 mio io", mio, 1'b0);
    chk("R4 lock second cycle", lock, 1'b1);
    complete();
    chk("R4 lock falls", lock, 1'b0);
    cyc_valid = 1'b1; cyc_lock = 1'b1; cyc_last = 1'b1;
    #1 chk("R5 locked refused in gap", cyc_ready, 1'b0);
    tick();
    chk("R5 lock still low", lock, 1'b0);
    #1 chk("R5 ready after gap", cyc_ready, 1'b1);
    tick();
    cyc_valid = 1'b0;
    chk("R5 new run lock", lock, 1'b1);
    complete();
    tick(); tick();
  endtask

  task automatic t_hold();
    issue(1'b1, 1'b0, 1'b0);
    complete();
    hold_req = 1'b1;
    tick(); tick();
    chk("R6 no hlda in lock", hlda, 1'b0);
    issue(1'b1, 1'b1, 1'b0);
    chk("R6 locked cycle under hold", lock, 1'b1);
    complete();
    chk("R7 lock fell", lock, 1'b0);
    chk("R7 hlda not yet", hlda, 1'b0);
    cyc_valid = 1'b1; cyc_lock = 1'b1; cyc_last = 1'b1;
    #1 chk("R7 locked waits", cyc_ready, 1'b0);
    tick();
    chk("R7 hlda after lock falls", hlda, 1'b1);
    chk("R7 no ads", ads, 1'b0);
    #1 chk("R6 ready low in hlda", cyc_ready, 1'b0);
    hold_req = 1'b0;
    tick();
    chk("R10 hlda drops", hlda, 1'b0);
    #1 chk("R10 ready back", cyc_ready, 1'b1);
    tick();
    cyc_valid = 1'b0;
    chk("R7 run after hold", lock, 1'b1);
    complete();
    tick(); tick();
  endtask

  task automatic t_ahold();
    issue(1'b1, 1'b1, 1'b1);
    ahold_req = 1'b1;
    tick();
    chk("R8 stall", stall, 1'b1);
    chk("R8 lock kept", lock, 1'b1);
    brdy = 1'b1;
    tick();
    brdy = 1'b0;
    chk("R8 cycle completes", lock, 1'b0);
    cyc_valid = 1'b1; cyc_lock = 1'b0; cyc_last = 1'b0;
    tick(); tick();
    chk("R8 no start", ads, 1'b0);
    #1 chk("R8 ready low", cyc_ready, 1'b0);
    ahold_req = 1'b0;
    #1 chk("R8 ready released", cyc_ready, 1'b1);
    tick();
    cyc_valid = 1'b0;
    chk("R8 start after ahold", ads, 1'b1);
    complete();
    tick();
  endtask

  task automatic t_boff();
    issue(1'b1, 1'b1, 1'b1);
    boff_req = 1'b1; brdy = 1'b1;
    tick();
    chk("R9 lock in boff", lock, 1'b1);
    chk("R9 stall", stall, 1'b1);
    tick();
    chk("R9 brdy ignored", lock, 1'b1);
    chk("R9 no ads in boff", ads, 1'b0);
    boff_req = 1'b0; brdy = 1'b0;
    tick();
    chk("R9 restart ads", ads, 1'b1);
    chk("R9 restart lock", lock, 1'b1);
    chk("R9 restart mio", mio, 1'b1);
    brdy = 1'b1;
    tick();
    chk("R9 ready in ads clock ignored", lock, 1'b1);
    tick();
    brdy = 1'b0;
    chk("R9 completes", lock, 1'b0);
    tick(); tick();
  endtask

  bit finished = 1'b0;

  initial begin
    t_reset();
    t_plain();
    t_lockrun();
    t_hold();
    t_ahold();
    t_boff();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule